// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit turns a virtual address into a physical address through a small on-chip table of segment entries. The top bits of the virtual address select an entry; the remaining bits are an offset into that segment. Each entry stores a valid flag, a base, a bound and a write-enable right. The unit adds the base to the offset and reports a fault code when the entry is invalid, when the offset reaches the bound, or when a write targets a read-only segment. Read-only segments let two address spaces share one physical region, with a copy made only on the first write.

Lookups use a valid/ready request and return one registered response per accepted request. The table is loaded through a separate write port. That port only works while the privileged input is high. A write attempted without privilege leaves the table unchanged and pulses a separate privilege-error output.

Top module: `seg_xlate`

## Requirements
- R1: After reset every table entry is invalid, `rsp_valid` and `priv_err` are low and `req_ready` is high.
- R2: `req_ready` is low exactly in cycles where `tbl_we` and `priv` are both high, and high otherwise.
- R3: An accepted request (`req_valid` and `req_ready`) gives `rsp_valid` high on the next cycle. `rsp_valid` is low after any cycle with no accepted request, and then `rsp_pa` and `rsp_fault` are zero.
- R4: The segment number is `req_va[21:20]` and the offset is `req_va[19:0]`. On a fault-free access, `rsp_pa` equals the entry base plus the zero-extended offset, modulo 2^24.
- R5: If the offset is greater than or equal to the entry bound, `rsp_fault` is 1 (bound) and `rsp_pa` is 0.
- R6: A write (`req_write`=1) within bound to a valid entry whose write right is 0 gives `rsp_fault` 2 (write-protect) and `rsp_pa` 0.
- R7: A lookup that selects an invalid entry gives `rsp_fault` 3 and `rsp_pa` 0, whatever the offset or direction.
- R8: Fault priority is invalid (3) over bound (1) over write-protect (2). Code 0 means no fault.
- R9: Reads of read-only segments and reads or writes of writable segments within bound give `rsp_fault` 0.
- R10: A table write with `priv`=1 stores base, bound, write right and valid flag at `tbl_idx`. Lookups accepted from the next cycle onward use the new values.
- R11: A table write with `priv`=0 leaves the table unchanged and sets `priv_err` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit accepts a request this cycle |
| req_va | input | 22 | Virtual address (segment, offset) |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response fields are valid |
| rsp_pa | output | 24 | Physical address, zero on fault |
| rsp_fault | output | 2 | 0 none, 1 bound, 2 write-protect, 3 invalid entry |
| priv | input | 1 | Privileged mode |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 2 | Entry to write |
| tbl_base | input | 24 | New base |
| tbl_bound | input | 20 | New bound (exclusive limit on offset) |
| tbl_rw | input | 1 | New write right (1 = writable) |
| tbl_vld | input | 1 | New valid flag |
| priv_err | output | 1 | Pulse: unprivileged table write attempted |

## Verification
The response to a request accepted at one clock edge appears after that edge and stays valid until the next one. The bench drives each request on a falling edge and samples `rsp_valid`, `rsp_pa` and `rsp_fault` on the next falling edge. `req_ready` is combinational, so it is checked in the same half cycle in which `tbl_we` is driven. `priv_err` and the table contents change at the edge that ends a write cycle. The bench therefore checks `priv_err` one falling edge later and confirms that a rejected write had no effect by looking up the entry it targeted.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 20,
  parameter int PA_BITS  = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [SEG_BITS+OFF_BITS-1:0] req_va,
  input  logic                         req_write,
  output logic                         rsp_valid,
  output logic [PA_BITS-1:0]           rsp_pa,
  output logic [1:0]                   rsp_fault,
  input  logic                         priv,
  input  logic                         tbl_we,
  input  logic [SEG_BITS-1:0]          tbl_idx,
  input  logic [PA_BITS-1:0]           tbl_base,
  input  logic [OFF_BITS-1:0]          tbl_bound,
  input  logic                         tbl_rw,
  input  logic                         tbl_vld,
  output logic                         priv_err
);
  localparam int NSEG    = 1 << SEG_BITS;
  localparam int VA_BITS = SEG_BITS + OFF_BITS;
  localparam logic [1:0] F_NONE  = 2'd0;
  localparam logic [1:0] F_BOUND = 2'd1;
  localparam logic [1:0] F_WPROT = 2'd2;
  localparam logic [1:0] F_INVAL = 2'd3;

  logic [PA_BITS-1:0]  base_q  [NSEG];
  logic [OFF_BITS-1:0] bound_q [NSEG];
  logic [NSEG-1:0]     rw_q, vld_q;

  logic                tbl_ok, accept;
  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic [1:0]          fault_c;
  logic [PA_BITS-1:0]  pa_c;

  assign tbl_ok    = tbl_we & priv;
  assign req_ready = ~tbl_ok;
  assign accept    = req_valid & req_ready;
  assign seg       = req_va[VA_BITS-1:OFF_BITS];
  assign off       = req_va[OFF_BITS-1:0];
  assign pa_c      = base_q[seg] + PA_BITS'(off);

  always_comb begin
    if (!vld_q[seg])                  fault_c = F_INVAL;
    else if (off >= bound_q[seg])     fault_c = F_BOUND;
    else if (req_write && !rw_q[seg]) fault_c = F_WPROT;
    else                              fault_c = F_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rw_q  <= '0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        bound_q[i] <= '0;
      end
    end else if (tbl_ok) begin
      vld_q[tbl_idx]   <= tbl_vld;
      rw_q[tbl_idx]    <= tbl_rw;
      base_q[tbl_idx]  <= tbl_base;
      bound_q[tbl_idx] <= tbl_bound;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= F_NONE;
      rsp_pa    <= '0;
      priv_err  <= 1'b0;
    end else begin
      rsp_valid <= accept;
      rsp_fault <= accept ? fault_c : F_NONE;
      rsp_pa    <= (accept && fault_c == F_NONE) ? pa_c : '0;
      priv_err  <= tbl_we & ~priv;
    end
  end

  // R3: one response per accepted request, one cycle later
  a_r3_rsp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R3: idle response carries zeros
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_pa == '0 && rsp_fault == F_NONE));
  // R5, R6, R7: faulting response has no address
  a_r5_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != F_NONE) |-> rsp_pa == '0);
  // R6: write-protect only follows a write request
  a_r6_wprot_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_fault != F_WPROT);
  // R11: unprivileged table write flags an error next cycle
  a_r11_priv_err: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && !priv) |=> priv_err);
  // R2: a lookup is never accepted together with a privileged table write
  a_r2_no_accept_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && priv && req_valid) |=> !rsp_valid);
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [21:0] req_va = '0;
  logic        req_ready, rsp_valid, priv_err;
  logic [23:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        priv = 0, tbl_we = 0, tbl_rw = 0, tbl_vld = 0;
  logic [1:0]  tbl_idx = '0;
  logic [23:0] tbl_base = '0;
  logic [19:0] tbl_bound = '0;

  int checks = 0, errors = 0;

  logic [23:0] m_base [4];
  logic [19:0] m_bound[4];
  logic        m_rw   [4];
  logic        m_vld  [4];

  always #2 clk = ~clk;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .priv(priv), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_base(tbl_base), .tbl_bound(tbl_bound),
    .tbl_rw(tbl_rw), .tbl_vld(tbl_vld), .priv_err(priv_err));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(logic [21:0] va, logic wr);
    logic [1:0]  s = va[21:20];
    logic [19:0] o = va[19:0];
    if (!m_vld[s])          return 2'd3;
    if (o >= m_bound[s])    return 2'd1;
    if (wr && !m_rw[s])     return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [23:0] exp_pa(logic [21:0] va, logic wr);
    if (exp_fault(va, wr) != 2'd0) return 24'd0;
    return m_base[va[21:20]] + {4'd0, va[19:0]};
  endfunction

  task automatic lookup(logic [21:0] va, logic wr, string tag);
    @(negedge clk);
    req_valid = 1; req_va = va; req_write = wr;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_fault"}, rsp_fault, exp_fault(va, wr));
    chk({tag, " rsp_pa"}, rsp_pa, exp_pa(va, wr));
  endtask

  task automatic twrite(logic [1:0] idx, logic [23:0] b, logic [19:0] bd,
                        logic rw, logic vld, logic p);
    @(negedge clk);
    tbl_we = 1; tbl_idx = idx; tbl_base = b; tbl_bound = bd;
    tbl_rw = rw; tbl_vld = vld; priv = p; req_valid = 1; req_va = '0;
    #1 chk("R2 req_ready during table write", req_ready, !p);
    @(negedge clk);
    tbl_we = 0; req_valid = 0; priv = 0;
    chk("R3 rsp_valid matches acceptance", rsp_valid, !p);
    chk("R11 priv_err pulse", priv_err, !p);
    if (p) begin
      m_base[idx] = b; m_bound[idx] = bd; m_rw[idx] = rw; m_vld[idx] = vld;
    end
    @(negedge clk);
    chk("R11 priv_err one cycle", priv_err, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5E6A11));
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_bound[i] = 0; m_rw[i] = 0; m_vld[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 priv_err after reset", priv_err, 0);
    chk("R1 req_ready after reset", req_ready, 1);
    chk("R3 idle rsp_pa", rsp_pa, 0);
    lookup(22'h000010, 0, "R1 R7 entry invalid after reset");

    twrite(0, 24'h02a000, 20'h03200, 1, 1, 1);
    twrite(1, 24'h014000, 20'h05000, 1, 1, 1);
    twrite(2, 24'h008000, 20'h00400, 0, 1, 1);

    lookup(22'h102000, 0, "R4 R10 seg1 read");
    chk("R4 seg1 pa value", rsp_pa, 24'h016000);
    lookup(22'h102000, 1, "R9 seg1 write");
    lookup(22'h0031ff, 1, "R4 R9 seg0 last byte");
    lookup(22'h003200, 0, "R5 seg0 at bound");
    chk("R5 code", rsp_fault, 1);
    lookup(22'h2003ff, 0, "R9 ro read");
    lookup(22'h2003ff, 1, "R6 ro write");
    chk("R6 code", rsp_fault, 2);
    lookup(22'h200500, 1, "R8 bound over wprot");
    chk("R8 code bound", rsp_fault, 1);
    lookup(22'h3fffff, 1, "R7 R8 invalid over bound");
    chk("R8 code invalid", rsp_fault, 3);

    twrite(1, 24'hffff00, 20'h00fff, 0, 1, 0);
    lookup(22'h102000, 0, "R11 unpriv write ignored");
    chk("R11 pa unchanged", rsp_pa, 24'h016000);
    twrite(3, 24'hfff000, 20'hfffff, 1, 1, 1);
    lookup(22'h3ff000, 0, "R4 R10 wraparound");

    // back-to-back requests
    @(negedge clk);
    req_valid = 1; req_va = 22'h100010; req_write = 0;
    @(negedge clk);
    chk("R3 b2b first valid", rsp_valid, 1);
    chk("R4 b2b first pa", rsp_pa, 24'h014010);
    req_va = 22'h200010; req_write = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R6 b2b second fault", rsp_fault, 2);
    @(negedge clk);
    chk("R3 valid drops when idle", rsp_valid, 0);
    chk("R3 idle fault zero", rsp_fault, 0);

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 10 == 0) begin
        twrite(2'($urandom), 24'($urandom), 20'($urandom % 20'h1000),
               1'($urandom), ($urandom % 5) != 0, ($urandom % 4) != 0);
      end else begin
        logic [1:0]  s = 2'($urandom);
        logic [19:0] o;
        if ($urandom % 2) o = 20'($urandom % (32'(m_bound[s]) + 16));
        else o = 20'($urandom);
        lookup({s, o}, 1'($urandom), "R4-rand R5 R6 R7 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule